// File: doc/BRIEF.md
# Input Change Interrupt Monitor

This block watches a 16-pin general-purpose port, organised as two 8-bit halves, and requests attention through an active-low, open-drain style interrupt line. Each half keeps a reference copy of its pin levels. Any pin configured as an input whose synchronized level differs from its reference raises the request. The request is a level comparison, not a latched event. If the pin goes back to its reference level, the request withdraws without any read.

A read strobe for a half loads that half's reference from the synchronized levels sampled on the same clock edge. The loaded value is the data that the read returns. The other half is left alone. The open-drain line is modelled as a pull-down enable together with the logical level seen on the wire. The direction bits arrive from an external register. Pins set as outputs are masked from the comparison. A pin that becomes an input while it disagrees with its reference raises the request at once. This is intended behaviour.

Top module: `gpio_chg_irq`

## Requirements
- R1: While reset is held for at least three clock edges with steady pins, the reference loads the pin levels. After release `rd_data_o` equals the pins, `irq_pull_o` is 0 and `irq_n_o` is 1.
- R2: Pins are changed between clock edges. If an input pin (direction bit 1) changes to differ from its reference, `irq_pull_o` becomes 1 after the third rising edge following the change, and not earlier.
- R3: If every differing input pin returns to its reference level and no read occurs, `irq_pull_o` returns to 0 after the third rising edge following the return.
- R4: A read strobe bit h (bit 0 = pins 7:0, bit 1 = pins 15:8) is high at an edge. That edge loads bits [8h+7:8h] of `rd_data_o` with the synchronized pin levels of that half.
- R5: The same edge that loads a half's reference also clears that half's contribution to `irq_pull_o`.
- R6: A read of one half leaves the other half's reference unchanged. It also leaves a pending mismatch in the other half in place.
- R7: A pin whose direction bit is 0 (output) never causes `irq_pull_o` to be 1.
- R8: A direction bit changes from 0 to 1 while that pin's synchronized level differs from its reference. `irq_pull_o` becomes 1 after the next rising edge.
- R9: `irq_n_o` is at all times the inverse of `irq_pull_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl_i | input | 16 | Asynchronous pin levels |
| dir_in_i | input | 16 | Direction per pin, 1 = input |
| rd_stb_i | input | 2 | Read strobe per 8-bit half |
| rd_data_o | output | 16 | Reference snapshot, also the read data |
| irq_pull_o | output | 1 | Pull-down enable of the interrupt line |
| irq_n_o | output | 1 | Logical level of the interrupt line |

## Verification
A wrong reference value shows up directly on `rd_data_o` after the next read edge. It also leaves `irq_pull_o` stuck high, or missing, once the synchronizer has settled, which is within three edges. A mistake in the direction mask or the half selection shows on `irq_pull_o` one edge after the stimulus that exposes it. A missing or extra synchronizer stage moves the set and clear edges of R2 and R3 by one cycle. The bench samples exactly at the third edge, so it sees such a shift.

// File: rtl/gpio_chg_pkg.sv
// Package: default geometry for the input change interrupt monitor.
package gpio_chg_pkg;
    localparam int GPIO_W  = 16;  // pins in the port
    localparam int HALF_W  = 8;   // pins per independently read half
    localparam int SYNC_N  = 2;   // synchronizer depth
endpackage

// File: rtl/gpio_chg_sync.sv
// Module: gpio_chg_sync
// A multi-flop synchronizer for a bank of asynchronous levels.
// Assumes that the levels change slowly compared with the clock. There is
// no reset: the stages flush after STAGES edges.
module gpio_chg_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Purpose: first stage samples the asynchronous input.
    always_ff @(posedge clk) stg[0] <= d_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Purpose: each later stage resamples the previous one.
        always_ff @(posedge clk) stg[s] <= stg[s-1];
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_chg_snap.sv
// Module: gpio_chg_snap
// The reference register of one half. A read strobe loads it from the
// synchronized levels. During reset it tracks those levels, so nothing is
// pending when reset is released. It exports both its next value and its
// current value.
module gpio_chg_snap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb_i,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] ref_nxt_o,
    output logic [W-1:0] ref_q_o
);
    // Purpose: choose between a reload and a hold.
    always_comb ref_nxt_o = (!rst_n || rd_stb_i) ? lvl_i : ref_q_o;

    // Purpose: store the reference.
    always_ff @(posedge clk) ref_q_o <= ref_nxt_o;
endmodule

// File: rtl/gpio_chg_cmp.sv
// Module: gpio_chg_cmp
// Compares the synchronized levels against the next reference value and
// masks out pins set as outputs. It ORs the result into one registered
// request. Using the next reference lets a read clear on its own edge.
module gpio_chg_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] dir_in_i,
    input  logic [W-1:0] ref_nxt_i,
    output logic         req_o
);
    logic [W-1:0] diff;

    // Purpose: per-pin mismatch restricted to input pins.
    always_comb diff = (lvl_i ^ ref_nxt_i) & dir_in_i;

    // Purpose: register the ORed request.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= |diff;
    end
endmodule

// File: rtl/gpio_chg_irq.sv
// Module: gpio_chg_irq (top)
// Raises an interrupt request whenever a pin set as an input differs from the
// reference of its half. Reads of a half reload that half's reference.
// Assumes the direction bits are already in the clock domain.
module gpio_chg_irq
    import gpio_chg_pkg::*;
#(
    parameter int PORT_W = GPIO_W,
    parameter int PART_W = HALF_W,
    parameter int SYNC_D = SYNC_N
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PORT_W-1:0]          pin_lvl_i,
    input  logic [PORT_W-1:0]          dir_in_i,
    input  logic [PORT_W/PART_W-1:0]   rd_stb_i,
    output logic [PORT_W-1:0]          rd_data_o,
    output logic                       irq_pull_o,
    output logic                       irq_n_o
);
    localparam int N_PART = PORT_W / PART_W;

    logic [PORT_W-1:0] sync_lvl;
    logic [PORT_W-1:0] ref_nxt;
    logic [PORT_W-1:0] ref_q;

    gpio_chg_sync #(.W(PORT_W), .STAGES(SYNC_D)) u_sync (
        .clk (clk),
        .d_i (pin_lvl_i),
        .q_o (sync_lvl)
    );

    for (genvar h = 0; h < N_PART; h++) begin : g_part
        gpio_chg_snap #(.W(PART_W)) u_snap (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_stb_i  (rd_stb_i[h]),
            .lvl_i     (sync_lvl[h*PART_W +: PART_W]),
            .ref_nxt_o (ref_nxt[h*PART_W +: PART_W]),
            .ref_q_o   (ref_q[h*PART_W +: PART_W])
        );
    end

    gpio_chg_cmp #(.W(PORT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (sync_lvl),
        .dir_in_i  (dir_in_i),
        .ref_nxt_i (ref_nxt),
        .req_o     (irq_pull_o)
    );

    // Purpose: drive the line level and the read data.
    always_comb begin
        irq_n_o   = ~irq_pull_o;
        rd_data_o = ref_q;
    end
endmodule

// File: rtl/gpio_chg_chk.sv
// Module: gpio_chg_chk
// Assertion checker bound to gpio_chg_irq. It watches the synchronized
// levels, the direction bits, the strobes, the reference and the request.
module gpio_chg_chk #(
    parameter int PORT_W = 16,
    parameter int PART_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [PORT_W-1:0]         sync_lvl,
    input logic [PORT_W-1:0]         dir_in_i,
    input logic [PORT_W/PART_W-1:0]  rd_stb_i,
    input logic [PORT_W-1:0]         rd_data_o,
    input logic                      irq_pull_o
);
    localparam int N_PART = PORT_W / PART_W;

    // R2: an unread input mismatch raises the request on the next edge
    p_set_on_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (((sync_lvl ^ rd_data_o) & dir_in_i) != '0 && rd_stb_i == '0) |=> irq_pull_o);

    // R3: with no input mismatch the request is released on the next edge
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((sync_lvl ^ rd_data_o) & dir_in_i) == '0) |=> !irq_pull_o);

    // R5: reading every half clears the request on that edge
    p_all_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&rd_stb_i) |=> !irq_pull_o);

    // R7: with all pins as outputs there is no request
    p_outputs_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in_i == '0) |=> !irq_pull_o);

    for (genvar h = 0; h < N_PART; h++) begin : g_part_chk
        // R4: a read loads the synchronized levels of that half
        p_load_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stb_i[h] |=> rd_data_o[h*PART_W +: PART_W] == $past(sync_lvl[h*PART_W +: PART_W]));

        // R6: without its own strobe a half keeps its reference
        p_hold_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_stb_i[h] |=> $stable(rd_data_o[h*PART_W +: PART_W]));
    end
endmodule

bind gpio_chg_irq gpio_chg_chk #(.PORT_W(PORT_W), .PART_W(PART_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_lvl   (sync_lvl),
    .dir_in_i   (dir_in_i),
    .rd_stb_i   (rd_stb_i),
    .rd_data_o  (rd_data_o),
    .irq_pull_o (irq_pull_o)
);

// File: tb/test_gpio_chg_irq.sv
`timescale 1ns/1ps
module test_gpio_chg_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_lvl_i = 16'hA55A;
    logic [15:0] dir_in_i = 16'hFFFF;
    logic [1:0]  rd_stb_i = 2'b00;
    logic [15:0] rd_data_o;
    logic        irq_pull_o;
    logic        irq_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [15:0] mref;

    always #4 clk = ~clk;

    gpio_chg_irq i_gpio_chg_irq (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin_lvl_i), .dir_in_i(dir_in_i),
        .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o),
        .irq_pull_o(irq_pull_o), .irq_n_o(irq_n_o)
    );

    // Vector fields: pins[34:19], dir[18:3], read[2:1], expected request[0]
    localparam logic [34:0] VEC [13] = '{
        {16'hA55A, 16'hFFFF, 2'b00, 1'b0},  // quiet
        {16'hA55B, 16'hFFFF, 2'b00, 1'b1},  // R2 change
        {16'hA55A, 16'hFFFF, 2'b00, 1'b0},  // R3 return
        {16'hA55B, 16'hFFFE, 2'b00, 1'b0},  // R7 output pin
        {16'hA55B, 16'hFFFF, 2'b00, 1'b1},  // R8 switch to input
        {16'hA55B, 16'hFFFF, 2'b10, 1'b1},  // R6 high read keeps low
        {16'hA55B, 16'hFFFF, 2'b01, 1'b0},  // R5 low read clears
        {16'h355B, 16'hFFFF, 2'b00, 1'b1},  // R2 high change
        {16'h355B, 16'hFFFF, 2'b01, 1'b1},  // R6 low read keeps high
        {16'h355B, 16'h00FF, 2'b00, 1'b0},  // R7 high as outputs
        {16'h355B, 16'hFFFF, 2'b10, 1'b0},  // R5 high read clears
        {16'h355B, 16'hFFFF, 2'b00, 1'b0},  // R4 quiet
        {16'h0000, 16'hFFFF, 2'b11, 1'b0}   // R5 both halves read
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic irq_is(input string req, input logic e);
        chk(req, {31'd0, irq_pull_o}, {31'd0, e});
        chk("R9", {31'd0, irq_n_o}, {31'd0, ~e});
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset loads pins as the reference
        edges(5);
        rst_n = 1'b1;
        edges(1);
        mref = 16'hA55A;
        chk("R1", {16'd0, rd_data_o}, {16'd0, mref});
        irq_is("R1", 1'b0);

        for (int i = 0; i < 13; i++) begin
            pin_lvl_i = VEC[i][34:19];
            dir_in_i  = VEC[i][18:3];
            rd_stb_i  = 2'b00;
            edges(3);
            rd_stb_i  = VEC[i][2:1];
            edges(1);
            rd_stb_i  = 2'b00;
            if (VEC[i][1]) mref[7:0]  = pin_lvl_i[7:0];
            if (VEC[i][2]) mref[15:8] = pin_lvl_i[15:8];
            irq_is($sformatf("R2/R3/R5/R6/R7/R8 vec%0d", i), VEC[i][0]);
            chk($sformatf("R4/R6 ref vec%0d", i), {16'd0, rd_data_o}, {16'd0, mref});
        end

        // R7 then R8: output pin differs, then becomes an input
        pin_lvl_i = 16'h0001;
        dir_in_i  = 16'hFFFE;
        edges(4);
        irq_is("R7 directed", 1'b0);
        dir_in_i = 16'hFFFF;
        edges(1);
        irq_is("R8 one edge", 1'b1);

        // R4 and R5: low read loads 0001 and clears on the same edge
        rd_stb_i = 2'b01;
        edges(1);
        rd_stb_i = 2'b00;
        chk("R4 directed", {16'd0, rd_data_o}, 32'h0001);
        irq_is("R5 directed", 1'b0);

        // R2 latency: still low after two edges, high after the third
        pin_lvl_i = 16'h0003;
        edges(2);
        irq_is("R2 early", 1'b0);
        edges(1);
        irq_is("R2 third edge", 1'b1);

        // R3 latency: return without read
        pin_lvl_i = 16'h0001;
        edges(2);
        irq_is("R3 early", 1'b1);
        edges(1);
        irq_is("R3 third edge", 1'b0);
        chk("R3 ref kept", {16'd0, rd_data_o}, 32'h0001);

        // R1: second reset with new pins and a pending mismatch
        pin_lvl_i = 16'h1234;
        edges(4);
        rst_n = 1'b0;
        edges(4);
        rst_n = 1'b1;
        edges(1);
        chk("R1 reload", {16'd0, rd_data_o}, 32'h1234);
        irq_is("R1 reload", 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule